// File: doc/BRIEF.md
# Data Bus Inversion Codec

This block lowers switching activity on a 64-bit parallel data bus. A transmit-side encoder accepts a logical data word together with a transfer-valid strobe. For every 16-bit lane it counts how many wires would toggle against the levels it drove last. When more than half of a lane would toggle, it drives that lane with its polarity flipped. Bus levels and the four per-lane flip flags are active-low, as they appear at the pins.

A receive-side decoder accepts the bus levels, the flags and a valid strobe. It undoes any flip per lane, returns the word to active-high logical form and raises a matching valid output. Both halves are plain single-clock registered logic with one cycle of latency each. On idle clocks the encoder keeps the bus unchanged, and so its reference for the next decision stays the same. In a system the encoder outputs are wired to the decoder inputs across the link.

Each half is controlled by a two-state machine. The encoder is in `ENC_IDLE` (no transfer last cycle) or `ENC_SEND` (a word was driven last cycle). The transition to `ENC_SEND` is taken on any cycle with the transfer strobe high, and the transition to `ENC_IDLE` on any cycle with it low. The decoder has `DEC_IDLE` and `DEC_OUT`, with the same rules driven by its input valid.

Top module: `dbi_codec_top`

## Requirements
- R1: The bus has four lanes of 16 bits. Flag bit i (`bus_inv_n[i]`) belongs to bits 16*i+15 down to 16*i of both the bus levels and the logical word.
- R2: A lane is flipped only when 9 or more of its 16 wires would change level. With exactly 8 changes or fewer it is driven without a flip.
- R3: A lane's flag is driven low (asserted) exactly when that lane is driven flipped. A flipped lane puts the logical data bits on the wires unchanged.
- R4: A lane that is not flipped drives the bitwise complement of the logical data, because the wires are active-low.
- R5: The toggle count for a transfer is taken against the wire levels of the previous transfer as actually driven, including any flip applied to them.
- R6: On a cycle with the transfer strobe low, the encoder's bus levels and flags keep their previous values. The next decision uses those held levels.
- R7: After reset, all 64 bus levels and all four flags are high, both valid outputs are low, and the decoded word is zero.
- R8: One cycle after the decoder's input valid is high, the decoded word appears. For each lane, it is the bus levels when that lane's flag is low, and the complement of the levels when the flag is high.
- R9: Each stage's valid output equals its input strobe one cycle earlier. Back-to-back transfers are accepted on every cycle. The decoded word holds its value on cycles that follow an invalid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | Transfer strobe for the encoder |
| tx_data | input | 64 | Logical word to send, active high |
| bus_dq_n | output | 64 | Active-low wire levels driven by the encoder |
| bus_inv_n | output | 4 | Active-low per-lane flip flags |
| bus_vld | output | 1 | Encoder data-ready, one cycle after tx_valid |
| rx_dq_n | input | 64 | Wire levels seen by the decoder |
| rx_inv_n | input | 4 | Flip flags seen by the decoder |
| rx_vld | input | 1 | Data-ready seen by the decoder |
| rx_data | output | 64 | Recovered logical word |
| rx_valid | output | 1 | Valid for rx_data, one cycle after rx_vld |

## Verification
The bench builds the block with its default parameters: four lanes of 16 bits. With that lane width, every toggle count from 0 to 16 can be reached by hand on each lane in turn, since each word is built from the levels the bench model says were driven last. This covers both sides of the 8-versus-9 threshold on every flag bit. The decoder normally sees the encoder's outputs. For some checks the bench also drives it directly with mixed flags and with idle cycles, so the polarity rule and the hold behaviour are tested apart from the encoder.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
    typedef enum logic {
        ENC_IDLE = 1'b0,
        ENC_SEND = 1'b1
    } enc_state_t;

    typedef enum logic {
        DEC_IDLE = 1'b0,
        DEC_OUT  = 1'b1
    } dec_state_t;
endpackage

// File: rtl/dbi_lane_decide.sv
module dbi_lane_decide #(
    parameter int LANE_W = 16
) (
    input  logic [LANE_W-1:0] word_lane,
    input  logic [LANE_W-1:0] prev_lvl,
    output logic [LANE_W-1:0] next_lvl,
    output logic              next_flag_n
);
    localparam int HALF_W = LANE_W / 2;
    localparam int CNT_W  = $clog2(LANE_W + 1);

    logic [LANE_W-1:0] plain_lvl;
    logic [CNT_W-1:0]  toggles;

    always_comb begin
        plain_lvl = ~word_lane;
        toggles   = CNT_W'($countones(plain_lvl ^ prev_lvl));
        if (toggles > CNT_W'(HALF_W)) begin
            next_lvl    = word_lane;
            next_flag_n = 1'b0;
        end else begin
            next_lvl    = plain_lvl;
            next_flag_n = 1'b1;
        end
    end
endmodule

// File: rtl/dbi_encoder.sv
module dbi_encoder
    import dbi_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] out_lvl_n,
    output logic [DATA_W/LANE_W-1:0] out_flag_n,
    output logic              out_valid
);
    localparam int NLANE = DATA_W / LANE_W;
    localparam int HALF_W = LANE_W / 2;

    enc_state_t state_q, state_d;
    logic [DATA_W-1:0] lvl_d;
    logic [NLANE-1:0]  flag_d;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        dbi_lane_decide #(.LANE_W(LANE_W)) decide_i (
            .word_lane   (in_data[g*LANE_W +: LANE_W]),
            .prev_lvl    (out_lvl_n[g*LANE_W +: LANE_W]),
            .next_lvl    (lvl_d[g*LANE_W +: LANE_W]),
            .next_flag_n (flag_d[g])
        );

        // R2: no driven transfer toggles more than half a lane
        p_lane_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> ($countones(out_lvl_n[g*LANE_W +: LANE_W]
                          ^ $past(out_lvl_n[g*LANE_W +: LANE_W])) <= HALF_W));

        // R3: flag low exactly when the wires carry the logical bits
        p_flag_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> ((!out_flag_n[g]) ==
                          (out_lvl_n[g*LANE_W +: LANE_W] == $past(in_data[g*LANE_W +: LANE_W]))));
    end

    always_comb begin
        unique case (in_valid)
            1'b1:    state_d = ENC_SEND;
            default: state_d = ENC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENC_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_lvl_n  <= '1;
            out_flag_n <= '1;
        end else if (state_d == ENC_SEND) begin
            out_lvl_n  <= lvl_d;
            out_flag_n <= flag_d;
        end
    end

    assign out_valid = (state_q == ENC_SEND);

    // R6: idle cycles leave the wires and flags unchanged
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_lvl_n) && $stable(out_flag_n)));

    // R9: valid follows the strobe by one cycle
    p_enc_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
endmodule

// File: rtl/dbi_decoder.sv
module dbi_decoder
    import dbi_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_lvl_n,
    input  logic [DATA_W/LANE_W-1:0] in_flag_n,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid
);
    localparam int NLANE = DATA_W / LANE_W;

    dec_state_t state_q, state_d;
    logic [DATA_W-1:0] word_d;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        always_comb begin
            if (!in_flag_n[g]) word_d[g*LANE_W +: LANE_W] = in_lvl_n[g*LANE_W +: LANE_W];
            else               word_d[g*LANE_W +: LANE_W] = ~in_lvl_n[g*LANE_W +: LANE_W];
        end

        // R8: a lane flagged as flipped is passed through as it is on the wires
        p_flip_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !in_flag_n[g]) |=>
                (out_data[g*LANE_W +: LANE_W] == $past(in_lvl_n[g*LANE_W +: LANE_W])));
    end

    always_comb begin
        unique case (in_valid)
            1'b1:    state_d = DEC_OUT;
            default: state_d = DEC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DEC_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  out_data <= '0;
        else if (state_d == DEC_OUT) out_data <= word_d;
    end

    assign out_valid = (state_q == DEC_OUT);

    // R9: decoded word holds after an invalid input
    p_dec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
endmodule

// File: rtl/dbi_codec_top.sv
module dbi_codec_top #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] bus_dq_n,
    output logic [DATA_W/LANE_W-1:0] bus_inv_n,
    output logic              bus_vld,
    input  logic [DATA_W-1:0] rx_dq_n,
    input  logic [DATA_W/LANE_W-1:0] rx_inv_n,
    input  logic              rx_vld,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);
    dbi_encoder #(.DATA_W(DATA_W), .LANE_W(LANE_W)) enc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (tx_valid),
        .in_data    (tx_data),
        .out_lvl_n  (bus_dq_n),
        .out_flag_n (bus_inv_n),
        .out_valid  (bus_vld)
    );

    dbi_decoder #(.DATA_W(DATA_W), .LANE_W(LANE_W)) dec_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_vld),
        .in_lvl_n  (rx_dq_n),
        .in_flag_n (rx_inv_n),
        .out_data  (rx_data),
        .out_valid (rx_valid)
    );

    // R7: nothing is flagged or valid right after reset
    p_reset_quiet_r7: assert property (@(posedge clk)
        $rose(rst_n) |-> (bus_inv_n == '1 && !bus_vld && !rx_valid));
endmodule

// File: tb/dbi_codec_top_tb_top.sv
`timescale 1ns/1ps
module dbi_codec_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_valid = 1'b0;
    logic [63:0] tx_data = '0;
    logic [63:0] bus_dq_n;
    logic [3:0]  bus_inv_n;
    logic        bus_vld;
    logic [63:0] rx_data;
    logic        rx_valid;

    logic        ovr = 1'b0;
    logic [63:0] ovr_dq = '0;
    logic [3:0]  ovr_inv = '1;
    logic        ovr_vld = 1'b0;
    logic [63:0] rx_dq_n;
    logic [3:0]  rx_inv_n;
    logic        rx_vld;

    assign rx_dq_n  = ovr ? ovr_dq  : bus_dq_n;
    assign rx_inv_n = ovr ? ovr_inv : bus_inv_n;
    assign rx_vld   = ovr ? ovr_vld : bus_vld;

    always #2 clk = ~clk;

    dbi_codec_top dut_i (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
        .bus_dq_n(bus_dq_n), .bus_inv_n(bus_inv_n), .bus_vld(bus_vld),
        .rx_dq_n(rx_dq_n), .rx_inv_n(rx_inv_n), .rx_vld(rx_vld),
        .rx_data(rx_data), .rx_valid(rx_valid)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [63:0] mref = '1;
    logic [3:0]  mflag = '1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // model of one encoder decision, from the requirements
    task automatic model(input logic [63:0] d, output logic [63:0] lv, output logic [3:0] fl);
        for (int g = 0; g < 4; g++) begin
            logic [15:0] plain;
            int t;
            plain = ~d[g*16 +: 16];
            t = $countones(plain ^ mref[g*16 +: 16]);
            if (t > 8) begin lv[g*16 +: 16] = d[g*16 +: 16]; fl[g] = 1'b0; end
            else       begin lv[g*16 +: 16] = plain;         fl[g] = 1'b1; end
        end
    endtask

    // one transfer followed by one idle cycle
    task automatic send(input logic [63:0] d, input string tag);
        logic [63:0] lv;
        logic [3:0] fl;
        model(d, lv, fl);
        tx_valid = 1'b1; tx_data = d;
        @(negedge clk);
        chk(bus_dq_n == lv, {tag, " levels"}, bus_dq_n, lv);
        chk(bus_inv_n == fl, {tag, " flags"}, {60'd0, bus_inv_n}, {60'd0, fl});
        chk(bus_vld, {tag, " R9 enc valid"}, {63'd0, bus_vld}, 64'd1);
        mref = lv; mflag = fl;
        tx_valid = 1'b0; tx_data = ~d;
        @(negedge clk);
        chk(rx_data == d, {tag, " R8 decoded"}, rx_data, d);
        chk(rx_valid, {tag, " R9 dec valid"}, {63'd0, rx_valid}, 64'd1);
        chk(bus_dq_n == mref && bus_inv_n == mflag, {tag, " R6 idle hold"}, bus_dq_n, mref);
        chk(!bus_vld, {tag, " R9 enc idle"}, {63'd0, bus_vld}, 64'd0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R7 reset state
        chk(bus_dq_n == '1, "R7 levels", bus_dq_n, '1);
        chk(bus_inv_n == '1, "R7 flags", {60'd0, bus_inv_n}, 64'hF);
        chk(!bus_vld && !rx_valid, "R7 valids", {62'd0, bus_vld, rx_valid}, 64'd0);
        chk(rx_data == '0, "R7 data", rx_data, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4 R5: every toggle count on every lane
        for (int g = 0; g < 4; g++) begin
            for (int k = 0; k <= 16; k++) begin
                logic [63:0] d;
                logic [15:0] mask;
                mask = 16'((32'h1 << k) - 1);
                mask = (mask << (g * 3)) | (mask >> (16 - g * 3));
                d = ~mref;
                d[g*16 +: 16] = ~(mref[g*16 +: 16] ^ mask);
                send(d, $sformatf("R1 R2 R3 R4 R5 lane%0d k%0d", g, k));
                chk(bus_inv_n[g] == (k > 8 ? 1'b0 : 1'b1), "R2 threshold",
                    {63'd0, bus_inv_n[g]}, {63'd0, (k <= 8)});
            end
        end

        // patterned words across all lanes
        send(64'h0000_0000_0000_0000, "R4 zeros");
        send(64'hFFFF_FFFF_FFFF_FFFF, "R5 ones");
        send(64'h5555_AAAA_00FF_FF00, "R5 mixed");
        send(64'hA5A5_5A5A_F0F0_0F0F, "R5 mixed2");

        // R9 back-to-back transfers
        begin
            logic [63:0] a, b, la, lb;
            logic [3:0] fa, fb;
            a = 64'h1234_5678_9ABC_DEF0;
            b = 64'hEDCB_A987_6543_210F;
            model(a, la, fa);
            tx_valid = 1'b1; tx_data = a;
            @(negedge clk);
            chk(bus_dq_n == la && bus_inv_n == fa, "R9 b2b first", bus_dq_n, la);
            mref = la;
            model(b, lb, fb);
            tx_data = b;
            @(negedge clk);
            chk(bus_dq_n == lb && bus_inv_n == fb, "R5 b2b second", bus_dq_n, lb);
            chk(rx_data == a && rx_valid, "R9 b2b dec first", rx_data, a);
            mref = lb;
            tx_valid = 1'b0;
            @(negedge clk);
            chk(rx_data == b && rx_valid, "R9 b2b dec second", rx_data, b);
            @(negedge clk);
            chk(!rx_valid && rx_data == b, "R9 dec hold", rx_data, b);
        end

        // R8 direct decoder injection with mixed flags (flag bit i = lane i)
        ovr = 1'b1;
        ovr_dq = 64'h0F0F_3333_CCCC_F0F0;
        ovr_inv = 4'b0101;
        ovr_vld = 1'b1;
        @(negedge clk);
        chk(rx_data == 64'h0F0F_CCCC_CCCC_0F0F && rx_valid, "R8 mixed flags",
            rx_data, 64'h0F0F_CCCC_CCCC_0F0F);
        ovr_vld = 1'b0;
        ovr_dq = 64'h1111_2222_3333_4444;
        ovr_inv = 4'b0000;
        @(negedge clk);
        chk(rx_data == 64'h0F0F_CCCC_CCCC_0F0F && !rx_valid, "R9 ignore invalid",
            rx_data, 64'h0F0F_CCCC_CCCC_0F0F);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule